// File: doc/BRIEF.md
# Register Lock Scoreboard for Pipeline Interlocking

This block tracks which architectural registers have a result still in flight. It holds one lock bit per register: a clear bit means the register's contents are valid and may be read, and a set bit means a producer has not yet written its result. When an instruction leaves operand fetch and is allowed to proceed, the lock of its destination register is set. The lock is cleared only when the producing instruction's result is actually written back.

Because release is tied to write-back and not to a fixed pipeline depth, a producer of any latency is covered, including a load whose data returns after an unpredictable delay. Forwarding paths and the register file itself live elsewhere. The pipeline presents the instruction in operand fetch on the issue port and reports completed results on the write-back port. It holds the instruction in place while `stall` is high.

`stall` is formed combinationally from the lock bits as they stand at the start of the cycle. A write-back in cycle t therefore frees a dependent instruction in cycle t+1. The full lock vector is also driven out so the surrounding pipeline can observe it.

Top module: `reg_lock_scoreboard`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), every lock bit is cleared, so `lockVec` is all zeros and `stall` is low after reset.
- R2: An issue that is not stalled and has `issueWritesDest` high sets the lock bit at index `issueDest`. The bit reads 1 on `lockVec` after the next rising clock edge.
- R3: A write-back (`wbValid` high) clears the lock bit at index `wbDest` at the next rising edge. Releasing a register that is not locked leaves every lock bit unchanged.
- R4: With `issueValid` high, `stall` is high in the same cycle when an enabled source (`issueUseA` with `issueSrcA`, or `issueUseB` with `issueSrcB`) names a locked register.
- R5: With `issueValid` and `issueWritesDest` high, `stall` is high when `issueDest` is already locked. This keeps writes to the same register in order.
- R6: A source whose enable is low, and a destination when `issueWritesDest` is low, never cause a stall. `stall` is low whenever `issueValid` is low.
- R7: A stalled issue changes no lock bit.
- R8: When a write-back release and an accepted issue's lock name the same register in the same cycle, the register ends up locked.
- R9: A release and a lock on different registers in the same cycle both take effect at the next edge.
- R10: A lock persists for any number of cycles until its write-back arrives. A dependent instruction stalls for that whole time, however long the producer's latency.
- R11: `stall` depends only on the lock bits held at the start of the cycle. A write-back of the blocking register in the same cycle does not lower `stall` until the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is present in operand fetch |
| issueUseA | input | 1 | First source operand is read |
| issueSrcA | input | IDX_W | First source register number |
| issueUseB | input | 1 | Second source operand is read |
| issueSrcB | input | IDX_W | Second source register number |
| issueWritesDest | input | 1 | The instruction produces a register result |
| issueDest | input | IDX_W | Destination register number |
| wbValid | input | 1 | A result is being written back this cycle |
| wbDest | input | IDX_W | Register number being written back |
| stall | output | 1 | Hold the instruction in operand fetch |
| lockVec | output | NUM_REGS | Current lock bits, bit i for register i |

## Verification
The embedded properties watch every cycle for the following. An accepted lock must appear after the edge. A release must clear its bit unless the lock targets the same register. A simultaneous lock and release of the same register must leave it locked. Quiet cycles must leave the vector unchanged, a stalled issue must raise no lock strobe, and an idle port must not stall.

Some behaviour is shown only by the bench's scenarios. These are the exact number of stall cycles behind a long-latency load, the one-cycle gap between write-back and resumption, the write-after-write hold, and the masking of unused operand fields. A behavioural model compares the stall and the lock vector on every clock through directed and random traffic.

// File: rtl/lockbit_pkg.sv
package lockbit_pkg;

  // Strobes from the control module to the lock-bit storage.
  typedef struct packed {
    logic setEn;  // lock issueDest at the next edge
    logic clrEn;  // release wbDest at the next edge
  } lockStrobes_t;

endpackage

// File: rtl/lockbit_ctrl.sv
module lockbit_ctrl
  import lockbit_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  logic                issueUseA,
  input  logic [IDX_W-1:0]    issueSrcA,
  input  logic                issueUseB,
  input  logic [IDX_W-1:0]    issueSrcB,
  input  logic                issueWritesDest,
  input  logic [IDX_W-1:0]    issueDest,
  input  logic                wbValid,
  input  logic [NUM_REGS-1:0] lockVec,
  output logic                stall,
  output lockStrobes_t        strobes
);

  logic srcALocked;
  logic srcBLocked;
  logic destLocked;

  // Look up a register's lock bit. Out-of-range numbers count as free.
  function automatic logic lookup(input logic [NUM_REGS-1:0] vec,
                                  input logic [IDX_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) hit = vec[i];
    end
    return hit;
  endfunction

  always_comb begin
    srcALocked = issueUseA && lookup(lockVec, issueSrcA);
    srcBLocked = issueUseB && lookup(lockVec, issueSrcB);
    destLocked = issueWritesDest && lookup(lockVec, issueDest);
    stall      = issueValid && (srcALocked || srcBLocked || destLocked);
  end

  always_comb begin
    strobes.setEn = issueValid && issueWritesDest && !stall;
    strobes.clrEn = wbValid;
  end

  // R7: a held instruction never raises the lock strobe.
  a_r7_stall_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && stall) |-> !strobes.setEn);

  // R6: with no instruction present nothing is held.
  a_r6_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !issueValid |-> !stall);

  // R5: an accepted writer always found its destination unlocked.
  a_r5_set_on_free: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setEn |-> !lockVec[issueDest]);

endmodule

// File: rtl/lockbit_store.sv
module lockbit_store
  import lockbit_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lockStrobes_t        strobes,
  input  logic [IDX_W-1:0]    setIdx,
  input  logic [IDX_W-1:0]    clrIdx,
  output logic [NUM_REGS-1:0] lockVec
);

  logic [NUM_REGS-1:0] lockQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    logic hitSet;
    logic hitClr;
    assign hitSet = strobes.setEn && (setIdx == IDX_W'(g));
    assign hitClr = strobes.clrEn && (clrIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lockQ[g] <= 1'b0;
      end else if (hitSet) begin
        lockQ[g] <= 1'b1;       // lock takes priority over release
      end else if (hitClr) begin
        lockQ[g] <= 1'b0;
      end
    end
  end

  assign lockVec = lockQ;

  // R1: right after reset is released no register is locked.
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (lockVec == '0));

  // R2: an accepted lock is visible after the edge.
  a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setEn |=> lockVec[$past(setIdx)]);

  // R3: a release not overridden by a lock clears its bit.
  a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrEn && !(strobes.setEn && setIdx == clrIdx))
      |=> !lockVec[$past(clrIdx)]);

  // R8: same-register lock and release leaves the register locked.
  a_r8_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.setEn && strobes.clrEn && setIdx == clrIdx)
      |=> lockVec[$past(setIdx)]);

  // R10: with no strobe the lock bits hold.
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.setEn && !strobes.clrEn) |=> $stable(lockVec));

endmodule

// File: rtl/reg_lock_scoreboard.sv
module reg_lock_scoreboard
  import lockbit_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  logic                issueUseA,
  input  logic [IDX_W-1:0]    issueSrcA,
  input  logic                issueUseB,
  input  logic [IDX_W-1:0]    issueSrcB,
  input  logic                issueWritesDest,
  input  logic [IDX_W-1:0]    issueDest,
  input  logic                wbValid,
  input  logic [IDX_W-1:0]    wbDest,
  output logic                stall,
  output logic [NUM_REGS-1:0] lockVec
);

  lockStrobes_t strobes;

  lockbit_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .issueValid      (issueValid),
    .issueUseA       (issueUseA),
    .issueSrcA       (issueSrcA),
    .issueUseB       (issueUseB),
    .issueSrcB       (issueSrcB),
    .issueWritesDest (issueWritesDest),
    .issueDest       (issueDest),
    .wbValid         (wbValid),
    .lockVec         (lockVec),
    .stall           (stall),
    .strobes         (strobes)
  );

  lockbit_store #(.NUM_REGS(NUM_REGS)) uStore (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .setIdx  (issueDest),
    .clrIdx  (wbDest),
    .lockVec (lockVec)
  );

  // R11: a stalled instruction sees the same lock bits until the next edge.
  a_r11_stall_from_state: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueUseA && lockVec[issueSrcA]) |-> stall);

endmodule

// File: tb/sim_reg_lock_scoreboard.sv
`timescale 1ns/1ps
module sim_reg_lock_scoreboard;

  localparam int NREG = 32;
  localparam int IW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issueValid = 1'b0, issueUseA = 1'b0, issueUseB = 1'b0, issueWritesDest = 1'b0;
  logic [IW-1:0] issueSrcA = '0, issueSrcB = '0, issueDest = '0, wbDest = '0;
  logic wbValid = 1'b0;
  logic stall;
  logic [NREG-1:0] lockVec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curReq = "R1";
  bit modelOn = 1'b0;
  bit [NREG-1:0] mdl = '0;

  always #4 clk = ~clk;   // 125 MHz

  reg_lock_scoreboard #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueUseA(issueUseA), .issueSrcA(issueSrcA),
    .issueUseB(issueUseB), .issueSrcB(issueSrcB),
    .issueWritesDest(issueWritesDest), .issueDest(issueDest),
    .wbValid(wbValid), .wbDest(wbDest),
    .stall(stall), .lockVec(lockVec)
  );

  function automatic bit expStall();
    return issueValid && ((issueUseA && mdl[issueSrcA]) ||
                          (issueUseB && mdl[issueSrcB]) ||
                          (issueWritesDest && mdl[issueDest]));
  endfunction

  // Behavioural reference, updated on every edge.
  always @(posedge clk) begin
    bit [NREG-1:0] nxt;
    if (!rst_n) begin
      mdl <= '0;
    end else begin
      nxt = mdl;
      if (wbValid) nxt[wbDest] = 1'b0;
      if (issueValid && issueWritesDest && !expStall()) nxt[issueDest] = 1'b1;
      mdl <= nxt;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (modelOn && rst_n) begin
      check(stall == expStall(), curReq, "stall", stall, expStall());
      check(lockVec == mdl, curReq, "lockVec", lockVec, mdl);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    issueValid = 0; issueUseA = 0; issueUseB = 0; issueWritesDest = 0; wbValid = 0;
  endtask

  task automatic issue(input bit ua, input int sa, input bit ub, input int sb,
                       input bit wd, input int d);
    issueValid = 1; issueUseA = ua; issueSrcA = IW'(sa); issueUseB = ub;
    issueSrcB = IW'(sb); issueWritesDest = wd; issueDest = IW'(d);
  endtask

  task automatic wb(input int d);
    wbValid = 1; wbDest = IW'(d);
  endtask

  initial begin
    // R1: reset state
    #2;
    check(lockVec == '0, "R1", "lockVec in reset", lockVec, 0);
    tick(); tick();
    rst_n = 1; modelOn = 1'b1;
    #2;
    check(lockVec == '0 && !stall, "R1", "after reset", lockVec, 0);
    tick();

    // R2: add-like producer locks r5
    curReq = "R2";
    issue(1, 3, 1, 4, 1, 5); tick(); idle();
    @(negedge clk);
    check(lockVec[5] == 1'b1, "R2", "lock r5", lockVec[5], 1);
    tick();

    // R4 / R10 / R11: dependent use of r5 held for three cycles
    curReq = "R4";
    issue(1, 6, 1, 5, 1, 8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check(stall == 1'b1, "R10", "dependent held", stall, 1);
      tick();
    end
    curReq = "R11";
    wb(5);
    @(negedge clk); check(stall == 1'b1, "R11", "stall in wb cycle", stall, 1);
    tick(); wbValid = 0;
    @(negedge clk); check(stall == 1'b0, "R11", "released next cycle", stall, 0);
    tick(); idle();
    @(negedge clk); check(lockVec[8] == 1'b1, "R2", "r8 locked", lockVec[8], 1);
    tick();

    // R5: write-after-write on r8 stalls, R7: and changes nothing
    curReq = "R5";
    issue(0, 0, 0, 0, 1, 8);
    @(negedge clk); check(stall == 1'b1, "R5", "WAW stall", stall, 1);
    tick();
    curReq = "R7";
    @(negedge clk); check(lockVec == 32'h0000_0100, "R7", "no change", lockVec, 32'h100);
    tick(); idle();

    // R6: unused fields point at r8 and do not stall
    curReq = "R6";
    issue(0, 8, 0, 8, 0, 8);
    @(negedge clk); check(stall == 1'b0, "R6", "unused fields", stall, 0);
    tick(); idle();
    issueUseA = 1; issueSrcA = 8;
    @(negedge clk); check(stall == 1'b0, "R6", "no valid", stall, 0);
    tick(); idle();

    // R3: spurious release of unlocked r20 changes nothing
    curReq = "R3";
    wb(20); tick(); idle();
    @(negedge clk); check(lockVec == 32'h0000_0100, "R3", "spurious release", lockVec, 32'h100);
    tick();

    // R8: release and lock of r12 together
    curReq = "R8";
    issue(0, 0, 0, 0, 1, 12); wb(12); tick(); idle();
    @(negedge clk); check(lockVec[12] == 1'b1, "R8", "lock wins", lockVec[12], 1);
    tick();

    // R9: release r8 while locking r13
    curReq = "R9";
    issue(1, 1, 0, 0, 1, 13); wb(8); tick(); idle();
    @(negedge clk); check(lockVec == 32'h0000_3000, "R9", "both applied", lockVec, 32'h3000);
    tick();

    // R10: load into r2 with 20-cycle latency, then use
    curReq = "R10";
    issue(0, 0, 0, 0, 1, 2); tick();
    issue(1, 2, 0, 0, 1, 3);
    begin
      int held = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); if (stall) held++;
        tick();
      end
      check(held == 20, "R10", "load-use held", held, 20);
    end
    wb(2); tick(); wbValid = 0;
    @(negedge clk); check(stall == 1'b0, "R10", "use proceeds", stall, 0);
    tick(); idle();

    // Random traffic against the model
    curReq = "R4";
    for (int i = 0; i < 2000; i++) begin
      issueValid = 1'($urandom_range(0, 1));
      issueUseA = 1'($urandom); issueUseB = 1'($urandom);
      issueWritesDest = 1'($urandom);
      issueSrcA = IW'($urandom_range(0, 7)); issueSrcB = IW'($urandom_range(0, 7));
      issueDest = IW'($urandom_range(0, 7));
      wbValid = ($urandom_range(0, 2) == 0);
      wbDest = IW'($urandom_range(0, 7));
      tick();
    end
    idle(); tick();

    // R1: asynchronous reset clears a populated vector
    curReq = "R1";
    modelOn = 1'b0;
    issue(0, 0, 0, 0, 1, 30); tick(); idle();
    #1 rst_n = 0; #1;
    check(lockVec == '0, "R1", "async reset", lockVec, 0);
    tick(); rst_n = 1; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule